// File: doc/BRIEF.md
# Parallel Concatenated Turbo Encoder

This block takes a frame of `FRAME_LEN` data bits on a serial input and turns it into a turbo codeword. Two identical recursive systematic convolutional encoders run in lockstep on one clock. One reads the frame in arrival order. The other reads the same stored frame through a fixed, irregular permutation of bit positions. The block buffers the whole frame first. It then sends the systematic bits, and while it does so both encoders step once per output bit and store their parity. Last, it sends the first parity stream and then the second.

Each frame comes in through a valid/ready handshake, with a start marker on the first bit. The codeword goes out as a serial stream with a valid strobe and an end marker on the last bit. A puncture control is sampled with the first bit of each frame. When it is set, half of each parity stream is dropped, so the rate rises from 1/3 to 1/2. Input ready stays low from the end of loading until the last codeword bit has left.

Top module: `turbo_pcc_enc`

## Requirements
- R1: While reset is held and after it is released, in_ready is 1, out_valid is 0 and out_eof is 0.
- R2: A bit is taken on a cycle with in_valid and in_ready both high. A bit taken with in_sof high becomes position 0 and throws away any partial frame. A bit without in_sof that arrives before any frame has started is discarded.
- R3: in_ready goes low in the cycle after the handshake of bit FRAME_LEN-1 and stays low while the codeword is being sent. out_valid is high in every cycle from that cycle through the out_eof cycle, with no gaps.
- R4: The first FRAME_LEN output bits are the data bits in arrival order. The first of them appears in the cycle after the last input handshake.
- R5: Parity stream 1 follows a_k = d_k ^ a_(k-1) ^ a_(k-2) and p_k = a_k ^ a_(k-2). Both delay elements are zero at each in_sof handshake, and no tail bits are appended.
- R6: Parity stream 2 uses the same recursion, but its input is d at position pi(k) = (PERM_F1*k + PERM_F2*k*k) mod FRAME_LEN. The defaults are 3 and 4, which give a permutation of 16 positions.
- R7: When puncturing is off, the codeword is 3*FRAME_LEN bits long: all data bits, then parity 1 for k = 0..FRAME_LEN-1, then parity 2 in the same order. out_eof is high only with the last bit.
- R8: punct_en is sampled only with the in_sof bit, and its value at any other time has no effect. When the sampled value is 1, parity 1 keeps only even k and parity 2 keeps only odd k, each in ascending order, so the codeword is 2*FRAME_LEN bits long.
- R9: In the cycle after out_eof, out_valid is 0 and in_ready is 1, so the next frame can start there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Data bit |
| in_sof | input | 1 | Marks the first bit of a frame |
| punct_en | input | 1 | Puncture request, sampled with the first bit |
| out_valid | output | 1 | Codeword bit is valid |
| out_bit | output | 1 | Codeword bit |
| out_eof | output | 1 | Marks the last codeword bit |

## Verification
The checker watches the timing skeleton on every cycle:
- ready drops after the final load bit;
- ready comes back right after the end marker;
- both encoder states are cleared at a frame start;
- the puncture setting holds steady through emission;
- the number of contiguous valid cycles up to the end marker is 3N or 2N, depending on the puncture setting.

Only the bench scenarios can show that bit values are correct. The bench sends all-zero and all-one frames, every single-one impulse, alternating and pseudo-random frames, restarted partial frames and stray pre-frame bits. It compares every output bit with a model that restates the recursion in delay form and computes the permutation directly.

// File: rtl/tpe_pkg.sv
`timescale 1ns/1ps
package tpe_pkg;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_SYS  = 2'd1,
    PH_PAR1 = 2'd2,
    PH_PAR2 = 2'd3
  } phase_e;

  // Quadratic permutation position: (f1*k + f2*k^2) mod n
  function automatic int unsigned perm_pos(int unsigned k, int unsigned n,
                                           int unsigned f1, int unsigned f2);
    return (f1 * k + f2 * k * k) % n;
  endfunction

  // One step of the 7/5 recursive systematic encoder.
  // st = {s2, s1}; result = {parity, next_s2, next_s1}
  function automatic logic [2:0] rsc75_next(logic [1:0] st, logic u);
    logic fb;
    fb = u ^ st[0] ^ st[1];
    return {fb ^ st[1], st[0], fb};
  endfunction

endpackage

// File: rtl/tpe_rsc.sv
`timescale 1ns/1ps
module tpe_rsc
  import tpe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       advance,
  input  logic       u,
  output logic       parity,
  output logic [1:0] state
);
  logic [2:0] step_res;

  assign step_res = rsc75_next(state, u);
  assign parity   = step_res[2];

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= '0;
    else if (clear)   state <= '0;
    else if (advance) state <= step_res[1:0];
  end
endmodule

// File: rtl/tpe_seq.sv
`timescale 1ns/1ps
module tpe_seq
  import tpe_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int AW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          punct_en,
  output phase_e        phase,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_pos,
  output logic [AW-1:0] rd_pos,
  output logic          punct_q,
  output logic          frame_start,
  output logic          load_done,
  output logic          emit_last
);
  localparam int IW = AW + 2;

  logic [IW-1:0] load_cnt, wr_cnt, idx, stride, idx_nx;
  logic          accept, par_end;

  assign in_ready    = (phase == PH_LOAD);
  assign accept      = in_valid && in_ready;
  assign frame_start = accept && in_sof;
  assign wr_en       = accept && (in_sof || load_cnt != '0);
  assign wr_cnt      = frame_start ? '0 : load_cnt;
  assign wr_pos      = wr_cnt[AW-1:0];
  assign load_done   = wr_en && (wr_cnt == IW'(FRAME_LEN - 1));
  assign stride      = punct_q ? IW'(2) : IW'(1);
  assign idx_nx      = idx + stride;
  assign par_end     = (idx_nx >= IW'(FRAME_LEN));
  assign emit_last   = (phase == PH_PAR2) && par_end;
  assign rd_pos      = idx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_LOAD;
      load_cnt <= '0;
      idx      <= '0;
      punct_q  <= 1'b0;
    end else begin
      case (phase)
        PH_LOAD: begin
          if (wr_en)       load_cnt <= load_done ? '0 : wr_cnt + IW'(1);
          if (frame_start) punct_q  <= punct_en;
          if (load_done) begin
            phase <= PH_SYS;
            idx   <= '0;
          end
        end
        PH_SYS: begin
          if (idx == IW'(FRAME_LEN - 1)) begin
            phase <= PH_PAR1;
            idx   <= '0;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        PH_PAR1: begin
          if (par_end) begin
            phase <= PH_PAR2;
            idx   <= punct_q ? IW'(1) : IW'(0);
          end else begin
            idx <= idx_nx;
          end
        end
        default: begin
          if (par_end) begin
            phase <= PH_LOAD;
            idx   <= '0;
          end else begin
            idx <= idx_nx;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/turbo_pcc_enc.sv
`timescale 1ns/1ps
module turbo_pcc_enc
  import tpe_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int PERM_F1   = 3,
  parameter int PERM_F2   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sof,
  input  logic punct_en,
  output logic out_valid,
  output logic out_bit,
  output logic out_eof
);
  localparam int AW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

  phase_e               phase;
  logic                 wr_en, punct_q, frame_start, load_done, emit_last;
  logic [AW-1:0]        wr_pos, rd_pos;
  logic [FRAME_LEN-1:0] data_q, par1_q, par2_q;
  logic [AW-1:0]        perm_tab [FRAME_LEN];
  logic                 sys_step;
  logic                 enc_u   [2];
  logic                 enc_par [2];
  logic [1:0]           enc_st  [2];
  logic [1:0]           enc1_st, enc2_st;

  tpe_seq #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .punct_en    (punct_en),
    .phase       (phase),
    .in_ready    (in_ready),
    .wr_en       (wr_en),
    .wr_pos      (wr_pos),
    .rd_pos      (rd_pos),
    .punct_q     (punct_q),
    .frame_start (frame_start),
    .load_done   (load_done),
    .emit_last   (emit_last)
  );

  // Constant permutation table, one entry per bit position
  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_perm
    assign perm_tab[g] = AW'(perm_pos(g, FRAME_LEN, PERM_F1, PERM_F2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     data_q <= '0;
    else if (wr_en) data_q[wr_pos] <= in_bit;
  end

  assign sys_step = (phase == PH_SYS);
  assign enc_u[0] = data_q[rd_pos];
  assign enc_u[1] = data_q[perm_tab[rd_pos]];

  for (genvar e = 0; e < 2; e++) begin : g_enc
    tpe_rsc u_rsc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (frame_start),
      .advance (sys_step),
      .u       (enc_u[e]),
      .parity  (enc_par[e]),
      .state   (enc_st[e])
    );
  end

  assign enc1_st = enc_st[0];
  assign enc2_st = enc_st[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par1_q <= '0;
      par2_q <= '0;
    end else if (sys_step) begin
      par1_q[rd_pos] <= enc_par[0];
      par2_q[rd_pos] <= enc_par[1];
    end
  end

  always_comb begin
    case (phase)
      PH_SYS:  out_bit = data_q[rd_pos];
      PH_PAR1: out_bit = par1_q[rd_pos];
      PH_PAR2: out_bit = par2_q[rd_pos];
      default: out_bit = 1'b0;
    endcase
  end

  assign out_valid = (phase != PH_LOAD);
  assign out_eof   = emit_last;
endmodule

// File: rtl/tpe_checker.sv
`timescale 1ns/1ps
module tpe_checker #(
  parameter int FRAME_LEN = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_eof,
  input logic       load_done,
  input logic       frame_start,
  input logic       punct_q,
  input logic [1:0] enc1_st,
  input logic [1:0] enc2_st
);
  localparam int CW = $clog2(3 * FRAME_LEN + 1);

  logic [CW-1:0] emit_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         emit_cnt <= '0;
    else if (out_valid) emit_cnt <= emit_cnt + CW'(1);
    else                emit_cnt <= '0;
  end

  assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (!in_ready && out_valid));

  assert_state_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (enc1_st == 2'b00 && enc2_st == 2'b00));

  assert_eof_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  assert_full_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && !punct_q) |-> (emit_cnt == CW'(3 * FRAME_LEN - 1)));

  assert_punct_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eof && punct_q) |-> (emit_cnt == CW'(2 * FRAME_LEN - 1)));

  assert_punct_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(punct_q));

  assert_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> (in_ready && !out_valid));
endmodule

bind turbo_pcc_enc tpe_checker #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_eof     (out_eof),
  .load_done   (load_done),
  .frame_start (frame_start),
  .punct_q     (punct_q),
  .enc1_st     (enc1_st),
  .enc2_st     (enc2_st)
);

// File: tb/turbo_pcc_enc_test.sv
`timescale 1ns/1ps
module turbo_pcc_enc_test;
  localparam int N  = 16;
  localparam int F1 = 3;
  localparam int F2 = 4;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, in_bit, in_sof, punct_en;
  logic out_valid, out_bit, out_eof;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  turbo_pcc_enc #(.FRAME_LEN(N), .PERM_F1(F1), .PERM_F2(F2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_sof(in_sof), .punct_en(punct_en),
    .out_valid(out_valid), .out_bit(out_bit), .out_eof(out_eof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv,
                     input string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Delay-form restatement of the recursion: a_k = d_k^a_(k-1)^a_(k-2), p_k = a_k^a_(k-2)
  function automatic logic [N-1:0] ref_parity(input logic [N-1:0] x);
    logic [N+1:0] a;
    logic [N-1:0] r;
    a = '0;
    for (int k = 0; k < N; k++) begin
      a[k+2] = x[k] ^ a[k+1] ^ a[k];
      r[k]   = a[k+2] ^ a[k];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] ref_shuffle(input logic [N-1:0] d);
    logic [N-1:0] x;
    for (int k = 0; k < N; k++) x[k] = d[(k * (F1 + F2 * k)) % N];
    return x;
  endfunction

  task automatic build(input logic [N-1:0] d, input logic p,
                       output logic [3*N-1:0] e, output int len);
    logic [N-1:0] p1, p2;
    int s;
    p1  = ref_parity(d);
    p2  = ref_parity(ref_shuffle(d));
    e   = '0;
    len = 0;
    s   = p ? 2 : 1;
    for (int k = 0; k < N; k++) begin e[len] = d[k]; len++; end
    for (int k = 0; k < N; k += s) begin e[len] = p1[k]; len++; end
    for (int k = (p ? 1 : 0); k < N; k += s) begin e[len] = p2[k]; len++; end
  endtask

  // Drives 'cut' bits; punct_en is only correct on the sof bit (R8 ignore test)
  task automatic send(input logic [N-1:0] d, input logic p, input int cut);
    for (int i = 0; i < cut; i++) begin
      @(negedge clk);
      chk(in_ready === 1'b1, "R3", int'(in_ready), 1, "ready during load");
      in_valid = 1'b1;
      in_bit   = d[i];
      in_sof   = (i == 0);
      punct_en = (i == 0) ? p : ~p;
    end
    if (cut == N) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
    end
  endtask

  task automatic receive(input logic [N-1:0] d, input logic p);
    logic [3*N-1:0] e;
    int len, got;
    bit done;
    string rq;
    build(d, p, e, len);
    got  = 0;
    done = 0;
    for (int cyc = 0; cyc < len + 4 && !done; cyc++) begin
      if (out_valid === 1'b1) begin
        rq = (got < N) ? "R4" : (p ? "R8" : ((got < 2 * N) ? "R5" : "R6"));
        chk(out_bit === e[got], rq, int'(out_bit), int'(e[got]), $sformatf("bit %0d", got));
        chk(in_ready === 1'b0, "R3", int'(in_ready), 0, "ready while sending");
        if (out_eof === 1'b1) begin
          chk(got == len - 1, p ? "R8" : "R7", got + 1, len, "codeword length");
          done = 1;
        end
        got++;
      end else begin
        chk(got == 0 && cyc == 0, "R3", got, 0, "gap in out_valid");
        done = (got != 0);
      end
      @(negedge clk);
    end
    chk(done, "R7", got, len, "end marker seen");
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R9", int'(in_ready), 1, "reopen after eof");
  endtask

  task automatic frame(input logic [N-1:0] d, input logic p);
    send(d, p, N);
    receive(d, p);
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; in_sof = 1'b0; punct_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && out_eof === 1'b0, "R1",
        int'({in_ready, out_valid, out_eof}), 4, "state in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && out_eof === 1'b0, "R1",
        int'({in_ready, out_valid, out_eof}), 4, "state after reset");

    frame('0, 1'b0);
    frame('1, 1'b0);
    frame('1, 1'b1);
    for (int k = 0; k < N; k++) frame(N'(1) << k, k[0]);   // impulses, R5 R6
    frame(16'hAAAA, 1'b0);
    frame(16'h5555, 1'b1);

    // R2: stray bits before any start marker are discarded
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = 1'b1; in_sof = 1'b0;
    end
    frame('0, 1'b0);

    // R2: partial frame is abandoned by a new start marker
    send(16'hFFFF, 1'b1, 5);
    frame(16'h1234, 1'b0);

    lfsr = 16'hACE1;
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 16; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      frame(lfsr, f[0]);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule